// File: doc/BRIEF.md
# SPI Memory Command Sequencer

This block carries out one read or one write of a serial memory over a four-wire SPI link. It takes a single request from a bus front end, builds the command frames the memory expects, and drives chip select, serial clock and data out while it captures data in. A read is one frame: read opcode, address, then 32 data bits clocked in. A write is always two frames. A one-byte write-enable frame goes first. After a chip-select gap, a frame carries the write opcode, the address and one, two or four data bytes. The address width, the serial clock divider and the clock mode (polarity and phase) are parameters.

Data bytes travel in little-endian order: the byte at the lowest memory address is on the wire first. Within each opcode, address or data byte, the most significant bit goes first. When the last frame is over and chip select has been high for one full serial clock period, the block raises a one-cycle `done` pulse. On that cycle the assembled read word is valid. The memory status register is never polled, so completion follows the frame directly.

The sequencer is a state machine with four states. `S_IDLE` accepts a request: a write moves to `S_WREN` and a read moves to `S_READ`. `S_WREN` moves to `S_WRITE` when the write-enable frame ends. `S_WRITE` and `S_READ` return to `S_IDLE` when their frame ends. The bit engine below it has five states. `P_IDLE` moves to `P_LEAD` on a frame start. `P_LEAD` moves to `P_TRAIL` at the leading clock edge. `P_TRAIL` moves back to `P_LEAD` at the trailing edge, or to `P_TAIL` after the last bit. `P_TAIL` moves to `P_GAP` when chip select rises. `P_GAP` returns to `P_IDLE` after one serial period with chip select high.

Top module: `spi_mem_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` equals CPOL, and `busy` and `done` are 0.
- R2: A read request (`req_write`=0) sends exactly one frame of 8+8*ABYTES+32 bits. The frame is opcode 8'h03, then `req_addr`, then 32 bit times in which data is clocked in. Each field is sent MSB first.
- R3: The read word is little-endian. The first byte received lands in `rdata[7:0]` and the fourth in `rdata[31:24]`, with each byte received MSB first.
- R4: A write request (`req_write`=1) first sends a separate 8-bit frame with opcode 8'h06. It then sends a frame with opcode 8'h02, `req_addr`, and the data bytes.
- R5: The number of write data bytes is set by `req_size`: 2'b00 gives 1 byte (`req_wdata[7:0]`) and 2'b01 gives 2 bytes. Both 2'b10 and 2'b11 give 4 bytes. Bytes go out starting with `req_wdata[7:0]`, then `[15:8]`, and so on.
- R6: The serial clock period is 2*DIV system clock cycles. The clock sits at the CPOL level whenever chip select is high.
- R7: With CPHA=0, data out is stable at every leading edge and data in is captured there. With CPHA=1, both of these happen at the trailing edge.
- R8: Between the two frames of a write, chip select stays high for at least 2*DIV system cycles.
- R9: `done` is a one-cycle pulse after the last frame, with chip select high and `busy` low. On that cycle `rdata` holds the word from a read.
- R10: A `req_valid` raised while `busy` is 1 is ignored and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Write size: 00 byte, 01 half-word, 10/11 word |
| req_addr | input | 8*ABYTES | Memory address sent in the frame |
| req_wdata | input | 32 | Write data, byte 0 sent first |
| busy | output | 1 | A request is being carried out |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read word, valid with `done` |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
Several properties are checked on every cycle by the assertions. The serial clock sits at its idle level while chip select is high and changes only on a divider tick. Chip select, once raised, is held for more than one cycle. `done` lasts a single cycle and comes with chip select high. The write state is entered only from the write-enable state, and `busy` holds until the bit engine reports a frame end. Other behaviour only the bench scenarios can show, using a memory model that decodes the wire in each clock mode. These are the exact bit content and length of each frame, the little-endian byte order, the serial period, the gap length between the two write frames, and the fact that a request raised while busy produces no extra frame.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_WREN  = 8'h06;

    typedef enum logic [1:0] {
        FR_WREN,
        FR_WRITE,
        FR_READ
    } frame_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WREN,
        S_WRITE,
        S_READ
    } seq_state_e;

    typedef enum logic [2:0] {
        P_IDLE,
        P_LEAD,
        P_TRAIL,
        P_TAIL,
        P_GAP
    } phy_state_e;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) < DIV); // R6

endmodule

// File: rtl/spi_frame_asm.sv
module spi_frame_asm
    import spi_seq_pkg::*;
#(
    parameter int ABYTES  = 3,
    parameter int AW      = 8 * ABYTES,
    parameter int FRAME_W = 8 + AW + 32,
    parameter int NB_W    = $clog2(FRAME_W + 1)
) (
    input  frame_kind_e          kind,
    input  logic [AW-1:0]        addr,
    input  logic [31:0]          wdata,
    input  logic [1:0]           size,
    output logic [FRAME_W-1:0]   frame,
    output logic [NB_W-1:0]      nbits
);
    logic [31:0] data_stream;
    logic [5:0]  data_bits;

    // byte 0 leads on the wire
    assign data_stream = {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]};

    always_comb begin
        unique case (size)
            2'b00:   data_bits = 6'd8;
            2'b01:   data_bits = 6'd16;
            default: data_bits = 6'd32;
        endcase
    end

    always_comb begin
        unique case (kind)
            FR_WREN: begin
                frame = {OP_WREN, {(FRAME_W - 8){1'b0}}};
                nbits = NB_W'(8);
            end
            FR_WRITE: begin
                frame = {OP_WRITE, addr, data_stream};
                nbits = NB_W'(8 + AW) + NB_W'(data_bits);
            end
            FR_READ: begin
                frame = {OP_READ, addr, 32'h0};
                nbits = NB_W'(FRAME_W);
            end
            default: begin
                frame = '0;
                nbits = '0;
            end
        endcase
    end

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_seq_pkg::*;
#(
    parameter bit CPOL    = 1'b0,
    parameter bit CPHA    = 1'b0,
    parameter int DIV     = 2,
    parameter int FRAME_W = 64,
    parameter int NB_W    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic [NB_W-1:0]    nbits,
    input  logic               miso,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    output logic [31:0]        rx_word,
    output logic               done
);
    phy_state_e         st, st_nx;
    logic               tick;
    logic [FRAME_W-1:0] tx_sr;
    logic [31:0]        rx_sr;
    logic [NB_W-1:0]    bit_cnt;
    logic               sclk_act;
    logic               cs_q;
    logic               mosi_q;
    logic               gap_half;
    logic               done_q;

    spi_half_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st != P_IDLE),
        .tick (tick)
    );

    assign sclk    = sclk_act ^ CPOL;
    assign cs_n    = cs_q;
    assign mosi    = mosi_q;
    assign rx_word = rx_sr;
    assign done    = done_q;

    always_comb begin
        st_nx = st;
        unique case (st)
            P_IDLE:  if (start) st_nx = P_LEAD;
            P_LEAD:  if (tick)  st_nx = P_TRAIL;
            P_TRAIL: if (tick)  st_nx = (bit_cnt == NB_W'(1)) ? P_TAIL : P_LEAD;
            P_TAIL:  if (tick)  st_nx = P_GAP;
            P_GAP:   if (tick && gap_half) st_nx = P_IDLE;
            default: st_nx = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= P_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr    <= '0;
            rx_sr    <= '0;
            bit_cnt  <= '0;
            sclk_act <= 1'b0;
            cs_q     <= 1'b1;
            mosi_q   <= 1'b0;
            gap_half <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                P_IDLE: begin
                    if (start) begin
                        cs_q     <= 1'b0;
                        bit_cnt  <= nbits;
                        gap_half <= 1'b0;
                        if (CPHA == 1'b0) begin
                            mosi_q <= frame[FRAME_W-1];
                            tx_sr  <= frame << 1;
                        end else begin
                            tx_sr  <= frame;
                        end
                    end
                end
                P_LEAD: begin
                    if (tick) begin
                        sclk_act <= 1'b1;
                        if (CPHA == 1'b0) begin
                            rx_sr <= {rx_sr[30:0], miso};
                        end else begin
                            mosi_q <= tx_sr[FRAME_W-1];
                            tx_sr  <= tx_sr << 1;
                        end
                    end
                end
                P_TRAIL: begin
                    if (tick) begin
                        sclk_act <= 1'b0;
                        bit_cnt  <= bit_cnt - 1'b1;
                        if (CPHA == 1'b1) begin
                            rx_sr <= {rx_sr[30:0], miso};
                        end else if (bit_cnt != NB_W'(1)) begin
                            mosi_q <= tx_sr[FRAME_W-1];
                            tx_sr  <= tx_sr << 1;
                        end
                    end
                end
                P_TAIL: begin
                    if (tick) begin
                        cs_q   <= 1'b1;
                        mosi_q <= 1'b0;
                    end
                end
                P_GAP: begin
                    if (tick) begin
                        if (gap_half) done_q   <= 1'b1;
                        else          gap_half <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == CPOL)); // R6
    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> $past(tick)); // R6
    AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n); // R9

endmodule

// File: rtl/spi_mem_seq.sv
module spi_mem_seq
    import spi_seq_pkg::*;
#(
    parameter int ABYTES = 3,
    parameter int DIV    = 2,
    parameter bit CPOL   = 1'b0,
    parameter bit CPHA   = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [8*ABYTES-1:0]   req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  busy,
    output logic                  done,
    output logic [31:0]           rdata,
    output logic                  spi_cs_n,
    output logic                  spi_sclk,
    output logic                  spi_mosi,
    input  logic                  spi_miso
);
    localparam int AW      = 8 * ABYTES;
    localparam int FRAME_W = 8 + AW + 32;
    localparam int NB_W    = $clog2(FRAME_W + 1);

    seq_state_e         state, state_nx;
    logic [AW-1:0]      lat_addr;
    logic [31:0]        lat_wdata;
    logic [1:0]         lat_size;
    frame_kind_e        f_kind;
    logic [AW-1:0]      f_addr;
    logic [31:0]        f_wdata;
    logic [1:0]         f_size;
    logic               phy_start;
    logic               phy_done;
    logic [FRAME_W-1:0] f_bits;
    logic [NB_W-1:0]    f_nbits;
    logic [31:0]        rx_word;
    logic               done_q;
    logic [31:0]        rdata_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = req_write ? S_WREN : S_READ;
            S_WREN:  if (phy_done)  state_nx = S_WRITE;
            S_WRITE: if (phy_done)  state_nx = S_IDLE;
            S_READ:  if (phy_done)  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // frame selection: new request while idle, write frame after write-enable
    always_comb begin
        f_addr  = lat_addr;
        f_wdata = lat_wdata;
        f_size  = lat_size;
        f_kind  = FR_READ;
        phy_start = 1'b0;
        unique case (state)
            S_IDLE: begin
                f_addr    = req_addr;
                f_wdata   = req_wdata;
                f_size    = req_size;
                f_kind    = req_write ? FR_WREN : FR_READ;
                phy_start = req_valid;
            end
            S_WREN: begin
                f_kind    = FR_WRITE;
                phy_start = phy_done;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_size  <= '0;
            done_q    <= 1'b0;
            rdata_q   <= '0;
        end else begin
            done_q <= phy_done && ((state == S_WRITE) || (state == S_READ));
            if (state == S_IDLE && req_valid) begin
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
                lat_size  <= req_size;
            end
            if (state == S_READ && phy_done) begin
                rdata_q <= {rx_word[7:0], rx_word[15:8], rx_word[23:16], rx_word[31:24]};
            end
        end
    end

    spi_frame_asm #(
        .ABYTES (ABYTES),
        .AW     (AW),
        .FRAME_W(FRAME_W),
        .NB_W   (NB_W)
    ) u_asm (
        .kind (f_kind),
        .addr (f_addr),
        .wdata(f_wdata),
        .size (f_size),
        .frame(f_bits),
        .nbits(f_nbits)
    );

    spi_bit_engine #(
        .CPOL   (CPOL),
        .CPHA   (CPHA),
        .DIV    (DIV),
        .FRAME_W(FRAME_W),
        .NB_W   (NB_W)
    ) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (phy_start),
        .frame  (f_bits),
        .nbits  (f_nbits),
        .miso   (spi_miso),
        .sclk   (spi_sclk),
        .cs_n   (spi_cs_n),
        .mosi   (spi_mosi),
        .rx_word(rx_word),
        .done   (phy_done)
    );

    assign busy  = (state != S_IDLE);
    assign done  = done_q;
    assign rdata = rdata_q;

    AST_WRITE_AFTER_WREN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) |-> ($past(state) == S_WREN || $past(state) == S_WRITE)); // R4
    AST_BUSY_UNTIL_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !phy_done) |=> busy); // R10
    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n); // R9

endmodule

// File: tb/tb_spi_mem_seq.sv
module spi_mem_model #(
    parameter bit CPOL = 1'b0,
    parameter bit CPHA = 1'b0,
    parameter int HDR  = 32
) (
    input  logic        clk,
    input  logic        clr,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        mosi,
    input  logic [31:0] rd_stream,
    output logic        miso
);
    logic [79:0] fbits [4];
    int flen [4];
    int nframes, idx, hi_cnt, min_gap, per_min, per_max, lead_cnt, idle_bad;
    bit have_lead;
    logic prev_sclk, prev_cs;

    assign miso = (idx >= HDR && idx < HDR + 32) ? rd_stream[31 - (idx - HDR)] : 1'b0;

    initial begin
        nframes = 0; idx = 0; hi_cnt = 0; min_gap = 999; per_min = 999; per_max = 0;
        lead_cnt = 0; idle_bad = 0; have_lead = 0; prev_sclk = CPOL; prev_cs = 1'b1;
        for (int i = 0; i < 4; i++) begin fbits[i] = '0; flen[i] = 0; end
    end

    always @(negedge clk) begin
        if (clr) begin
            nframes = 0; idx = 0; min_gap = 999; per_min = 999; per_max = 0;
            idle_bad = 0; have_lead = 0;
            for (int i = 0; i < 4; i++) begin fbits[i] = '0; flen[i] = 0; end
        end else begin
            lead_cnt++;
            if (prev_cs && !cs_n) begin
                idx = 0;
                have_lead = 0;
                if (nframes > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
                if (sclk !== CPOL) idle_bad = 1;
            end
            if (!cs_n && sclk !== prev_sclk) begin
                if (prev_sclk == CPOL) begin
                    if (have_lead) begin
                        if (lead_cnt < per_min) per_min = lead_cnt;
                        if (lead_cnt > per_max) per_max = lead_cnt;
                    end
                    have_lead = 1;
                    lead_cnt = 0;
                end
                if ((CPHA == 1'b0) == (prev_sclk == CPOL)) begin
                    if (idx < 80 && nframes < 4) fbits[nframes][79 - idx] = mosi;
                    idx++;
                end
            end
            if (!prev_cs && cs_n && nframes < 4) begin
                flen[nframes] = idx;
                nframes++;
            end
            if (cs_n) hi_cnt++;
            else      hi_cnt = 0;
        end
        prev_sclk = sclk;
        prev_cs   = cs_n;
    end
endmodule

module tb_spi_mem_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic        a_req_valid = 0, a_req_write = 0;
    logic [1:0]  a_req_size = 0;
    logic [23:0] a_req_addr = 0;
    logic [31:0] a_req_wdata = 0;
    logic        a_busy, a_done, a_cs_n, a_sclk, a_mosi, a_miso;
    logic [31:0] a_rdata, a_stream = 0;
    logic        a_clr = 0;

    logic        b_req_valid = 0, b_req_write = 0;
    logic [1:0]  b_req_size = 0;
    logic [15:0] b_req_addr = 0;
    logic [31:0] b_req_wdata = 0;
    logic        b_busy, b_done, b_cs_n, b_sclk, b_mosi, b_miso;
    logic [31:0] b_rdata, b_stream = 0;
    logic        b_clr = 0;

    spi_mem_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(a_req_valid), .req_write(a_req_write),
        .req_size(a_req_size), .req_addr(a_req_addr), .req_wdata(a_req_wdata),
        .busy(a_busy), .done(a_done), .rdata(a_rdata), .spi_cs_n(a_cs_n),
        .spi_sclk(a_sclk), .spi_mosi(a_mosi), .spi_miso(a_miso)
    );

    spi_mem_seq #(.ABYTES(2), .DIV(3), .CPOL(1'b1), .CPHA(1'b1)) dut_b (
        .clk(clk), .rst_n(rst_n), .req_valid(b_req_valid), .req_write(b_req_write),
        .req_size(b_req_size), .req_addr(b_req_addr), .req_wdata(b_req_wdata),
        .busy(b_busy), .done(b_done), .rdata(b_rdata), .spi_cs_n(b_cs_n),
        .spi_sclk(b_sclk), .spi_mosi(b_mosi), .spi_miso(b_miso)
    );

    spi_mem_model #(.CPOL(1'b0), .CPHA(1'b0), .HDR(32)) mem_a (
        .clk(clk), .clr(a_clr), .cs_n(a_cs_n), .sclk(a_sclk), .mosi(a_mosi),
        .rd_stream(a_stream), .miso(a_miso)
    );

    spi_mem_model #(.CPOL(1'b1), .CPHA(1'b1), .HDR(24)) mem_b (
        .clk(clk), .clr(b_clr), .cs_n(b_cs_n), .sclk(b_sclk), .mosi(b_mosi),
        .rd_stream(b_stream), .miso(b_miso)
    );

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_models();
        @(posedge clk); a_clr = 1; b_clr = 1;
        @(posedge clk); a_clr = 0; b_clr = 0;
        @(negedge clk);
    endtask

    task automatic issue_a(input logic wr, input logic [1:0] sz, input logic [23:0] ad,
                           input logic [31:0] wd);
        @(negedge clk);
        a_req_valid = 1; a_req_write = wr; a_req_size = sz; a_req_addr = ad; a_req_wdata = wd;
        @(negedge clk);
        a_req_valid = 0;
    endtask

    task automatic issue_b(input logic wr, input logic [1:0] sz, input logic [15:0] ad,
                           input logic [31:0] wd);
        @(negedge clk);
        b_req_valid = 1; b_req_write = wr; b_req_size = sz; b_req_addr = ad; b_req_wdata = wd;
        @(negedge clk);
        b_req_valid = 0;
    endtask

    // R9: single-cycle done with cs high and busy low
    task automatic wait_done(input bit use_b, input string tag, output logic [31:0] rd);
        int n;
        rd = '0;
        for (n = 0; n < 4000; n++) begin
            if ((use_b ? b_done : a_done) === 1'b1) break;
            @(negedge clk);
        end
        chk({tag, " R9 done seen"}, 80'(use_b ? b_done : a_done), 80'd1);
        chk({tag, " R9 cs high at done"}, 80'(use_b ? b_cs_n : a_cs_n), 80'd1);
        chk({tag, " R9 busy low at done"}, 80'(use_b ? b_busy : a_busy), 80'd0);
        rd = use_b ? b_rdata : a_rdata;
        @(negedge clk);
        chk({tag, " R9 done one cycle"}, 80'(use_b ? b_done : a_done), 80'd0);
    endtask

    task automatic t_reset();
        chk("R1 cs_n after reset", 80'(a_cs_n), 80'd1);
        chk("R1 sclk idle CPOL0", 80'(a_sclk), 80'd0);
        chk("R1 sclk idle CPOL1", 80'(b_sclk), 80'd1);
        chk("R1 busy after reset", 80'(a_busy), 80'd0);
        chk("R1 done after reset", 80'(a_done), 80'd0);
    endtask

    task automatic t_read_a(input logic [23:0] ad, input logic [31:0] stream,
                            input logic [31:0] exp_rd);
        logic [31:0] rd;
        clear_models();
        a_stream = stream;
        issue_a(1'b0, 2'b10, ad, 32'h0);
        wait_done(1'b0, "read_a", rd);
        repeat (4) @(negedge clk);
        chk("R2 read frame count", 80'(mem_a.nframes), 80'd1);
        chk("R2 read frame length", 80'(mem_a.flen[0]), 80'd64);
        chk("R2 R7 read frame bits", mem_a.fbits[0], {8'h03, ad, 48'h0});
        chk("R3 read data little-endian", 80'(rd), 80'(exp_rd));
        chk("R6 serial period min", 80'(mem_a.per_min), 80'd4);
        chk("R6 serial period max", 80'(mem_a.per_max), 80'd4);
        chk("R6 sclk idle at cs fall", 80'(mem_a.idle_bad), 80'd0);
    endtask

    task automatic t_write_a(input string tag, input logic [1:0] sz, input logic [23:0] ad,
                             input logic [31:0] wd, input int exp_len,
                             input logic [79:0] exp_bits);
        logic [31:0] rd;
        clear_models();
        issue_a(1'b1, sz, ad, wd);
        wait_done(1'b0, tag, rd);
        repeat (4) @(negedge clk);
        chk({tag, " R4 frame count"}, 80'(mem_a.nframes), 80'd2);
        chk({tag, " R4 wren length"}, 80'(mem_a.flen[0]), 80'd8);
        chk({tag, " R4 wren bits"}, mem_a.fbits[0], {8'h06, 72'h0});
        chk({tag, " R5 write length"}, 80'(mem_a.flen[1]), 80'(exp_len));
        chk({tag, " R5 R7 write bits"}, mem_a.fbits[1], exp_bits);
        chk({tag, " R8 gap >= 4"}, 80'(mem_a.min_gap >= 4), 80'd1);
    endtask

    task automatic t_ignore_busy_a();
        logic [31:0] rd;
        clear_models();
        a_stream = 32'h0;
        issue_a(1'b0, 2'b10, 24'h000010, 32'h0);
        repeat (3) @(negedge clk);
        issue_a(1'b1, 2'b10, 24'h777777, 32'hFFFFFFFF);
        wait_done(1'b0, "busy_a", rd);
        repeat (60) @(negedge clk);
        chk("R10 only one frame", 80'(mem_a.nframes), 80'd1);
        chk("R10 frame is the read", mem_a.fbits[0], {8'h03, 24'h000010, 48'h0});
        chk("R10 idle afterwards", 80'(a_busy), 80'd0);
    endtask

    task automatic t_read_b();
        logic [31:0] rd;
        clear_models();
        b_stream = 32'h01020304;
        issue_b(1'b0, 2'b10, 16'hBEEF, 32'h0);
        wait_done(1'b1, "read_b", rd);
        repeat (4) @(negedge clk);
        chk("R2 mode3 read length", 80'(mem_b.flen[0]), 80'd56);
        chk("R7 mode3 read bits", mem_b.fbits[0], {8'h03, 16'hBEEF, 56'h0});
        chk("R3 mode3 read data", 80'(rd), 80'h04030201);
        chk("R6 mode3 period", 80'(mem_b.per_max), 80'd6);
        chk("R6 mode3 idle level", 80'(mem_b.idle_bad), 80'd0);
    endtask

    task automatic t_write_b();
        logic [31:0] rd;
        clear_models();
        issue_b(1'b1, 2'b00, 16'h0042, 32'h000000E7);
        wait_done(1'b1, "write_b", rd);
        repeat (4) @(negedge clk);
        chk("R4 mode3 wren bits", mem_b.fbits[0], {8'h06, 72'h0});
        chk("R5 mode3 byte length", 80'(mem_b.flen[1]), 80'd32);
        chk("R7 mode3 byte bits", mem_b.fbits[1], {8'h02, 16'h0042, 8'hE7, 48'h0});
        chk("R8 mode3 gap >= 6", 80'(mem_b.min_gap >= 6), 80'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read_a(24'h123456, 32'h11223344, 32'h44332211);
        t_read_a(24'h00FF01, 32'hA5F00F5A, 32'h5A0FF0A5);
        t_write_a("word", 2'b10, 24'hABCDEF, 32'hDDCCBBAA, 64,
                  {8'h02, 24'hABCDEF, 32'hAABBCCDD, 16'h0});
        t_write_a("half", 2'b01, 24'h000100, 32'hFFFF5A6B, 48,
                  {8'h02, 24'h000100, 16'h6B5A, 32'h0});
        t_write_a("byte", 2'b00, 24'hFFFFFF, 32'h123456C3, 40,
                  {8'h02, 24'hFFFFFF, 8'hC3, 40'h0});
        t_write_a("size3", 2'b11, 24'h000004, 32'h87654321, 64,
                  {8'h02, 24'h000004, 32'h21436587, 16'h0});
        t_ignore_busy_a();
        t_read_b();
        t_write_b();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule